// File: doc/BRIEF.md
# Sixteen-Point Streaming FFT Pipeline

This block computes a 16-point discrete Fourier transform on a continuous stream of complex samples. It takes one sample per clock and returns one result per clock. Four cascaded stages each hold one radix-2 butterfly, a delay line and a routing switch. Stage `s` (counting from 1) delays by `16 >> s` samples (8, 4, 2, 1), in decimation-in-frequency order. The switch alternates in blocks of that length. One block loads the delay line while the stored twiddled differences drain to the next stage. The next block feeds the stored sample and the new one through the butterfly.

Inputs are 16-bit signed Q1.15 values. These are widened to an 18-bit word holding 4 integer and 14 fraction bits. Each stage moves one bit from fraction to integer (5.13, 6.12, 7.11, 8.10), so results are never scaled down. The twiddled difference clamps to the 18-bit extremes instead of wrapping. Results leave in bit-reversed index order, with a marker on output index 0. Frames may follow each other with no idle cycles.

Each stage runs a small controller:
- IDLE: no frame start has been seen since reset.
- FILL: loads the delay line and forwards stored differences.
- MERGE: runs the butterfly.

The transitions are:
- IDLE→FILL: on an accepted sample that carries the frame marker.
- FILL→MERGE and MERGE→FILL: after the stage's delay length of accepted samples.
- Any state→FILL: on an accepted sample carrying the frame marker, which also restarts the stage's sample position at 0.

A stage advances only on an accepted sample.

Top module: `fft16_stream`

## Requirements
- R1: Output number `p` of a frame (counting from 0 at the marker) equals X[k] = Σ x[n]·e^(−j2πkn/16), with k the 4-bit reversal of p. The result is given as an 18-bit signed integer equal to 1024 × the true value, where x[n] = input/32768. It is accurate to within 6 LSB.
- R2: With an uninterrupted frame, the marked output appears 18 clocks after the clock edge that accepted the marked input.
- R3: After reset `out_valid` and `out_sof` are 0. The first valid output of each frame carries `out_sof` = 1, and `out_sof` is never high without `out_valid`.
- R4: Frames sent back to back produce output with no gap cycles. Successive output markers are exactly 16 clocks apart, with 16 valid outputs between them.
- R5: Cycles with `in_valid` = 0 hold all stages and leave the results unchanged. An output is valid only if a sample was accepted 4 clocks earlier.
- R6: A frame of full-scale negative inputs (−32768 on both parts) gives −16384 on both parts at output 0 and 0 elsewhere, without wrap-around. Twiddled results clamp to the 18-bit signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_sof | input | 1 | Marks sample index 0 of a frame |
| in_re | input | 16 | Real part, signed Q1.15 |
| in_im | input | 16 | Imaginary part, signed Q1.15 |
| out_valid | output | 1 | Result present this cycle |
| out_sof | output | 1 | Marks output index 0 (bin 0) |
| out_re | output | 18 | Real part of result, signed 8.10 |
| out_im | output | 18 | Imaginary part of result, signed 8.10 |

## Verification
The bench sends a frame with idle cycles scattered through it. A stage that advanced without an accepted sample would shift its delay line out of step with its position count, and the bins of that frame and the next would come out wrong. Full-scale negative input tests the integer growth: a stage that dropped its extra integer bit would wrap bin 0 to a positive value. Measuring the marker distance and the valid count across back-to-back frames exposes a switch whose period is off by one, which would slip or duplicate samples at frame boundaries. Impulses and a pure tone place energy in known bins, so a wrong twiddle exponent or a missing bit reversal lands results in the wrong output slots.

// File: rtl/fft16_pkg.sv
package fft16_pkg;
    localparam int PTS      = 16;
    localparam int LOG_PTS  = $clog2(PTS);
    localparam int IN_W     = 16;
    localparam int WORD_W   = 18;
    localparam int TW_FRAC  = 16;
    localparam int TW_IDX_W = LOG_PTS - 1;
    localparam int PROD_W   = 2 * WORD_W + 1;
    localparam int EXT_W    = WORD_W - IN_W + 1;

    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (WORD_W - 1)) - 64'sd1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

    typedef struct packed {
        logic signed [WORD_W-1:0] re;
        logic signed [WORD_W-1:0] im;
    } cword_t;

    // cos(2*pi*k/16), scaled by 2^TW_FRAC
    function automatic logic signed [WORD_W-1:0] tw_cos(input logic [TW_IDX_W-1:0] k);
        case (k)
            3'd0:    return  18'sd65536;
            3'd1:    return  18'sd60547;
            3'd2:    return  18'sd46341;
            3'd3:    return  18'sd25080;
            3'd4:    return  18'sd0;
            3'd5:    return -18'sd25080;
            3'd6:    return -18'sd46341;
            default: return -18'sd60547;
        endcase
    endfunction

    // sin(2*pi*k/16), scaled by 2^TW_FRAC
    function automatic logic signed [WORD_W-1:0] tw_sin(input logic [TW_IDX_W-1:0] k);
        case (k)
            3'd0:    return 18'sd0;
            3'd1:    return 18'sd25080;
            3'd2:    return 18'sd46341;
            3'd3:    return 18'sd60547;
            3'd4:    return 18'sd65536;
            3'd5:    return 18'sd60547;
            3'd6:    return 18'sd46341;
            default: return 18'sd25080;
        endcase
    endfunction

    function automatic logic signed [WORD_W-1:0] clamp(input logic signed [PROD_W-1:0] v);
        if (v > SAT_HI)      return SAT_HI[WORD_W-1:0];
        else if (v < SAT_LO) return SAT_LO[WORD_W-1:0];
        else                 return v[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/fft16_bfly.sv
// Radix-2 butterfly: halved sum, and halved difference rotated by W16^tw_i.
module fft16_bfly
    import fft16_pkg::*;
(
    input  cword_t                a_i,
    input  cword_t                b_i,
    input  logic [TW_IDX_W-1:0]   tw_i,
    output cword_t                sum_o,
    output cword_t                dif_o
);
    logic signed [WORD_W:0]   s_re, s_im, d_re, d_im;
    logic signed [WORD_W-1:0] h_re, h_im, c_w, s_w;
    logic signed [PROD_W-1:0] acc_re, acc_im, sh_re, sh_im;

    always_comb begin
        s_re = {a_i.re[WORD_W-1], a_i.re} + {b_i.re[WORD_W-1], b_i.re};
        s_im = {a_i.im[WORD_W-1], a_i.im} + {b_i.im[WORD_W-1], b_i.im};
        d_re = {a_i.re[WORD_W-1], a_i.re} - {b_i.re[WORD_W-1], b_i.re};
        d_im = {a_i.im[WORD_W-1], a_i.im} - {b_i.im[WORD_W-1], b_i.im};
        // one fraction bit is given up per stage: value kept, range doubled
        h_re = d_re[WORD_W:1];
        h_im = d_im[WORD_W:1];
        c_w  = tw_cos(tw_i);
        s_w  = tw_sin(tw_i);
        // (h_re + j h_im)(c - j s)
        acc_re = PROD_W'(h_re) * PROD_W'(c_w) + PROD_W'(h_im) * PROD_W'(s_w);
        acc_im = PROD_W'(h_im) * PROD_W'(c_w) - PROD_W'(h_re) * PROD_W'(s_w);
        sh_re  = acc_re >>> TW_FRAC;
        sh_im  = acc_im >>> TW_FRAC;
        sum_o.re = s_re[WORD_W:1];
        sum_o.im = s_im[WORD_W:1];
        dif_o.re = clamp(sh_re);
        dif_o.im = clamp(sh_im);
    end
endmodule

// File: rtl/fft16_stage.sv
// One delay-feedback stage: delay line, butterfly and FILL/MERGE switch.
module fft16_stage
    import fft16_pkg::*;
#(
    parameter int STG = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  logic   in_sof,
    input  cword_t in_dat,
    output logic   out_valid,
    output logic   out_sof,
    output cword_t out_dat
);
    localparam int DLY = PTS >> STG;
    localparam int LD  = LOG_PTS - STG;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_MERGE} stg_state_e;

    stg_state_e           st, cur_st, nxt_st;
    logic [LOG_PTS-1:0]   pos, cur_pos, nxt_pos, low_pos;
    logic                 live, active, hit0;
    logic [TW_IDX_W-1:0]  tw_idx;
    cword_t               dq [DLY];
    cword_t               head, fifo_in, res, sum_w, dif_w;

    assign head    = dq[DLY-1];
    assign cur_pos = in_sof ? '0 : pos;
    assign cur_st  = in_sof ? ST_FILL : st;
    assign active  = in_valid && (cur_st != ST_IDLE);
    assign nxt_pos = cur_pos + 1'b1;
    assign nxt_st  = nxt_pos[LD] ? ST_MERGE : ST_FILL;
    assign hit0    = (cur_st == ST_MERGE) && (cur_pos == LOG_PTS'(DLY));
    assign low_pos = cur_pos & LOG_PTS'(DLY - 1);
    assign tw_idx  = TW_IDX_W'(low_pos << (STG - 1));

    fft16_bfly u_bfly (
        .a_i   (head),
        .b_i   (in_dat),
        .tw_i  (tw_idx),
        .sum_o (sum_w),
        .dif_o (dif_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            pos  <= '0;
            live <= 1'b0;
        end else if (active) begin
            st  <= nxt_st;
            pos <= nxt_pos;
            if (hit0) live <= 1'b1;
        end
    end

    // switch network
    always_comb begin
        unique case (cur_st)
            ST_IDLE:  begin fifo_in = in_dat; res = head;  end
            ST_FILL:  begin fifo_in = in_dat; res = head;  end
            ST_MERGE: begin fifo_in = dif_w;  res = sum_w; end
            default:  begin fifo_in = in_dat; res = head;  end
        endcase
    end

    // delay line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) dq[i] <= '0;
        end else if (active) begin
            dq[0] <= fifo_in;
            for (int i = 1; i < DLY; i++) dq[i] <= dq[i-1];
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_dat   <= '0;
        end else begin
            out_valid <= active && (live || hit0);
            out_sof   <= active && hit0;
            if (active) out_dat <= res;
        end
    end
endmodule

// File: rtl/fft16_stream.sv
module fft16_stream
    import fft16_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic signed [IN_W-1:0]   in_re,
    input  logic signed [IN_W-1:0]   in_im,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic signed [WORD_W-1:0] out_re,
    output logic signed [WORD_W-1:0] out_im
);
    cword_t in_word;
    cword_t lane_d [LOG_PTS+1];
    logic   lane_v [LOG_PTS+1];
    logic   lane_s [LOG_PTS+1];

    // Q1.15 to 4.14: sign-extend, drop one fraction bit
    assign in_word = {{{EXT_W{in_re[IN_W-1]}}, in_re[IN_W-1:1]},
                      {{EXT_W{in_im[IN_W-1]}}, in_im[IN_W-1:1]}};
    assign lane_d[0] = in_word;
    assign lane_v[0] = in_valid;
    assign lane_s[0] = in_sof;

    for (genvar g = 1; g <= LOG_PTS; g++) begin : g_stage
        fft16_stage #(.STG(g)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (lane_v[g-1]),
            .in_sof    (lane_s[g-1]),
            .in_dat    (lane_d[g-1]),
            .out_valid (lane_v[g]),
            .out_sof   (lane_s[g]),
            .out_dat   (lane_d[g])
        );
    end

    assign out_valid = lane_v[LOG_PTS];
    assign out_sof   = lane_s[LOG_PTS];
    assign out_re    = lane_d[LOG_PTS].re;
    assign out_im    = lane_d[LOG_PTS].im;
endmodule

// File: rtl/fft16_stream_chk.sv
module fft16_stream_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_sof
);
    assert_reset_clears_R3: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_sof_has_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    assert_sof_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> !$past(out_sof));

    // four registered stages between input and output
    assert_valid_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));
endmodule

bind fft16_stream fft16_stream_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sof   (out_sof)
);

// File: tb/fft16_stream_bench.sv
`timescale 1ns/1ps
module fft16_stream_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_sof = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic               out_valid, out_sof;
    logic signed [17:0] out_re, out_im;

    fft16_stream u_fft16_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_sof(out_sof),
        .out_re(out_re), .out_im(out_im)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_cmp = 0, n_bad = 0;
    real   q_re[$], q_im[$];
    bit    q_sof[$];
    string q_tag[$];
    int    m_cyc[$];
    bit    m_cont[$];
    int    xr[16], xi[16];
    int    seed = 7;

    function automatic int brev4(int p);
        return ((p & 1) << 3) | ((p & 2) << 1) | ((p & 4) >> 1) | ((p & 8) >> 3);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(int kind);
        for (int n = 0; n < 16; n++) begin
            case (kind)
                0: begin xr[n] = (n == 0) ? 16384 : 0; xi[n] = 0; end
                1: begin xr[n] = 0; xi[n] = (n == 3) ? -20000 : 0; end
                2: begin xr[n] = 8000; xi[n] = -4000; end
                3: begin
                    xr[n] = int'(12000.0 * $cos(2.0 * 3.14159265358979 * 5.0 * n / 16.0));
                    xi[n] = int'(12000.0 * $sin(2.0 * 3.14159265358979 * 5.0 * n / 16.0));
                end
                4: begin xr[n] = -32768; xi[n] = -32768; end
                5: begin
                    seed = seed * 1103515245 + 12345;
                    xr[n] = int'($signed(16'(seed >> 8)));
                    seed = seed * 1103515245 + 12345;
                    xi[n] = int'($signed(16'(seed >> 8)));
                end
                default: begin xr[n] = 0; xi[n] = 0; end
            endcase
        end
    endtask

    // scoreboard driver side: expected bins in bit-reversed slot order
    task automatic push_expect(string tag);
        for (int p = 0; p < 16; p++) begin
            int  k = brev4(p);
            real er = 0.0, ei = 0.0;
            for (int n = 0; n < 16; n++) begin
                real th = 2.0 * 3.14159265358979 * k * n / 16.0;
                er += xr[n] * $cos(th) + xi[n] * $sin(th);
                ei += xi[n] * $cos(th) - xr[n] * $sin(th);
            end
            q_re.push_back(er / 32.0);
            q_im.push_back(ei / 32.0);
            q_sof.push_back(p == 0);
            q_tag.push_back(tag);
        end
    endtask

    task automatic send_frame(int kind, bit gappy, bit scored, string tag);
        fill(kind);
        if (scored) push_expect(tag);
        for (int n = 0; n < 16; n++) begin
            if (gappy && (n % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (n == 0);
            in_re    = 16'(xr[n]);
            in_im    = 16'(xi[n]);
            if (n == 0 && scored) begin
                m_cyc.push_back(cyc + 1);
                m_cont.push_back(!gappy);
            end
        end
    endtask

    // scoreboard monitor side
    int prev_cyc = -1;
    bit prev_cont = 1'b0;
    int vcnt = 0;
    always @(negedge clk) begin : mon
        int    c0, ar, ai;
        bit    ct, es;
        real   er, ei, dr, di;
        string tg;
        if (rst_n && out_valid) begin
            if (out_sof && m_cyc.size() > 0) begin
                c0 = m_cyc.pop_front();
                ct = m_cont.pop_front();
                if (ct) check(cyc - c0 == 18, "R2", "marker latency", cyc - c0, 18);
                if (ct && prev_cont && prev_cyc >= 0) begin
                    check(cyc - prev_cyc == 16, "R4", "marker spacing", cyc - prev_cyc, 16);
                    check(vcnt == 16, "R4", "valid outputs per frame", vcnt, 16);
                end
                prev_cyc  = cyc;
                prev_cont = ct;
                vcnt      = 0;
            end
            vcnt++;
            if (q_re.size() > 0) begin
                er = q_re.pop_front();
                ei = q_im.pop_front();
                es = q_sof.pop_front();
                tg = q_tag.pop_front();
                ar = int'(out_re);
                ai = int'(out_im);
                dr = ar - er;
                di = ai - ei;
                check(dr <= 6.0 && dr >= -6.0, tg, "real part", ar, int'(er));
                check(di <= 6.0 && di >= -6.0, tg, "imag part", ai, int'(ei));
                check(out_sof == es, "R3", "frame marker", int'(out_sof), int'(es));
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5.0 * 20000);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R3", "valid idle after reset", int'(out_valid), 0);
        check(out_sof == 1'b0, "R3", "marker idle after reset", int'(out_sof), 0);
        send_frame(0, 1'b0, 1'b1, "R1");   // impulse at 0
        send_frame(1, 1'b0, 1'b1, "R1");   // imaginary impulse at 3
        send_frame(2, 1'b0, 1'b1, "R1");   // DC
        send_frame(3, 1'b0, 1'b1, "R1");   // tone in bin 5
        send_frame(4, 1'b0, 1'b1, "R6");   // full-scale negative
        send_frame(5, 1'b0, 1'b1, "R1");   // random
        send_frame(5, 1'b1, 1'b1, "R5");   // random with idle cycles
        send_frame(5, 1'b0, 1'b1, "R1");   // random after gaps
        send_frame(6, 1'b0, 1'b0, "R1");   // flush, not scored
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (40) @(negedge clk);
        check(q_re.size() == 0, "R1", "results left undelivered", q_re.size(), 0);
        check(m_cyc.size() == 0, "R3", "frames without output marker", m_cyc.size(), 0);
        summary();
        $finish;
    end
endmodule